// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block turns one 128-bit plaintext block into its AES-128 ciphertext under a 128-bit key. It uses a single shared round datapath that is reused over several clock cycles. A small controller walks through a fixed sequence of states:

- an idle state;
- a selection state before every round;
- an initial key-mixing round;
- nine full rounds;
- a final round without column mixing;
- a wrap state that clears the round index.

The round keys are expanded one step per round from the previous round key, so no key schedule is stored. Each transform stage (byte substitution, row rotation, column mixing, key mixing) has its own enable. When its enable is low, the stage passes its input through unchanged.

A user places the plaintext and key on their inputs and raises `start` for one cycle while the block is idle. The inputs must stay stable until `done`. Twenty-two clock edges after the edge that accepted `start`, the ciphertext register is loaded and `done` pulses for one cycle. A downstream consumer can take the ciphertext in that cycle or at any later time, because the register holds its value until the next completion.

`start` and `done` are plain control pins. There is no back-pressure: the ciphertext is never withdrawn. A `start` seen while the block is busy is ignored and is not queued.

Top module: `aes128_iter_enc`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done` is 0 and `ciphertext` is all zeros.
- R2: `start` is acted on only in the idle state. A `start` that is high while an encryption is in progress neither restarts it nor queues another one, so exactly one `done` pulse follows.
- R3: `done` is high for exactly one cycle. It is seen in the cycle after the 22nd rising edge that follows the edge that accepted `start`.
- R4: In the cycle where `done` is high, `ciphertext` equals the AES-128 encryption of `plaintext` under `key`. Byte 0 of every 128-bit value is bits [127:120]. The bytes form a 4x4 state filled column by column: byte index = row + 4*column. Row r of the state is rotated left by r positions.
- R5: Between completions, `ciphertext` is constant, even when `plaintext` and `key` change after `done`.
- R6: After a completion, the block returns to idle two edges after the loading edge. If `start` is held high continuously, successive `done` pulses are 25 cycles apart and each carries a correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an encryption; sampled only when idle |
| plaintext | input | 128 | Block to encrypt, byte 0 in bits [127:120]; held until `done` |
| key | input | 128 | Cipher key, same byte order; held until `done` |
| ciphertext | output | 128 | Registered result, updated when `done` rises |
| done | output | 1 | One-cycle completion pulse for the downstream stage |

## Verification
The bench uses two published key/plaintext pairs and a set of seeded random blocks, each checked against a reference encryption written inside the bench. A wrong byte order, a row rotated the wrong way, or column mixing left on in the last round would show up as a wrong ciphertext on every vector. An off-by-one in the round-counter branch shows up as a latency other than 22 edges, or as one round too many or too few. The bench also raises `start` in the middle of a run: a controller that restarted or queued on it would give a second pulse or a late one. Finally, it holds `start` high across completions, where a wrap state that failed to clear the round index would break the 25-cycle spacing.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  localparam int BLK_W  = 128;
  localparam int BYTE_W = 8;
  localparam int NBYTES = BLK_W / BYTE_W;
  localparam int NROW   = 4;
  localparam int NCOL   = NBYTES / NROW;
  localparam int WORD_W = BLK_W / NCOL;
  localparam int NR     = 10;
  localparam int RND_W  = $clog2(NR + 2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_KEYADD,
    ST_MID,
    ST_LAST,
    ST_WRAP
  } enc_fsm_t;

  // multiply by x in GF(2^8), modulus 0x11B
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  // substitution: multiplicative inverse (a^254) followed by the affine map
  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] inv;
    sq  = a;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_enc_ctrl.sv
module aes_enc_ctrl
  import aes_enc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic sel_ext,
  output logic use_in_key,
  output logic en_sub,
  output logic en_shift,
  output logic en_mix,
  output logic en_ark,
  output logic ld_work,
  output logic ld_out
);

  localparam logic [RND_W-1:0] RND_ZERO = '0;
  localparam logic [RND_W-1:0] RND_LAST = RND_W'(NR);
  localparam logic [RND_W-1:0] RND_MAX  = RND_W'(NR + 1);

  enc_fsm_t         fsm_q, fsm_d;
  logic [RND_W-1:0] rnd_q, rnd_d;

  always_comb begin
    fsm_d = fsm_q;
    unique case (fsm_q)
      ST_IDLE:   fsm_d = start ? ST_SEL : ST_IDLE;
      ST_SEL: begin
        if (rnd_q == RND_ZERO)      fsm_d = ST_KEYADD;
        else if (rnd_q < RND_LAST)  fsm_d = ST_MID;
        else if (rnd_q == RND_LAST) fsm_d = ST_LAST;
        else                        fsm_d = ST_WRAP;
      end
      ST_KEYADD: fsm_d = ST_SEL;
      ST_MID:    fsm_d = ST_SEL;
      ST_LAST:   fsm_d = ST_SEL;
      ST_WRAP:   fsm_d = ST_IDLE;
      default:   fsm_d = ST_IDLE;
    endcase
  end

  assign ld_work    = (fsm_q == ST_KEYADD) || (fsm_q == ST_MID) || (fsm_q == ST_LAST);
  assign ld_out     = (fsm_q == ST_LAST);
  assign use_in_key = (fsm_q == ST_KEYADD);
  assign en_ark     = ld_work;
  assign en_sub     = (fsm_q == ST_MID) || (fsm_q == ST_LAST);
  assign en_shift   = en_sub;
  assign en_mix     = (fsm_q == ST_MID);
  assign sel_ext    = (rnd_q == RND_ZERO);

  always_comb begin
    rnd_d = rnd_q;
    if (fsm_q == ST_WRAP) rnd_d = RND_ZERO;
    else if (ld_work)     rnd_d = rnd_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q <= ST_IDLE;
      rnd_q <= RND_ZERO;
    end else begin
      fsm_q <= fsm_d;
      rnd_q <= rnd_d;
    end
  end

  AST_RND_RANGE: assert property (@(posedge clk) disable iff (rst)
    rnd_q <= RND_MAX); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == ST_IDLE && !start) |=> (fsm_q == ST_IDLE)); // R2

  AST_WRAP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == ST_WRAP) |=> (fsm_q == ST_IDLE && rnd_q == RND_ZERO)); // R6

  AST_KEYADD_FIRST: assert property (@(posedge clk) disable iff (rst)
    (fsm_q == ST_KEYADD) |-> (rnd_q == RND_ZERO)); // R4

endmodule

// File: rtl/aes_round_dp.sv
module aes_round_dp
  import aes_enc_pkg::*;
(
  input  logic [BLK_W-1:0] din,
  input  logic [BLK_W-1:0] rkey,
  input  logic             en_sub,
  input  logic             en_shift,
  input  logic             en_mix,
  input  logic             en_ark,
  output logic [BLK_W-1:0] dout
);

  logic [BYTE_W-1:0] b_in  [NBYTES];
  logic [BYTE_W-1:0] b_sub [NBYTES];
  logic [BYTE_W-1:0] b_sh  [NBYTES];
  logic [BYTE_W-1:0] b_mx  [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam int ROW = i % NROW;
    localparam int COL = i / NROW;
    localparam int SRC = ROW + NROW * ((COL + ROW) % NCOL);
    localparam int HI  = BLK_W - 1 - BYTE_W * i;

    assign b_in[i]  = din[HI -: BYTE_W];
    assign b_sub[i] = en_sub ? sub_byte(b_in[i]) : b_in[i];
    assign b_sh[i]  = en_shift ? b_sub[SRC] : b_sub[i];
    assign dout[HI -: BYTE_W] = b_mx[i] ^ (en_ark ? rkey[HI -: BYTE_W] : '0);
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < NROW; r++) begin : g_row
      localparam int I0 = NROW * c + r;
      localparam int I1 = NROW * c + (r + 1) % NROW;
      localparam int I2 = NROW * c + (r + 2) % NROW;
      localparam int I3 = NROW * c + (r + 3) % NROW;
      assign b_mx[I0] = en_mix
        ? (gf_x2(b_sh[I0]) ^ gf_x2(b_sh[I1]) ^ b_sh[I1] ^ b_sh[I2] ^ b_sh[I3])
        : b_sh[I0];
    end
  end

endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_enc_pkg::*;
(
  input  logic [BLK_W-1:0]  key_prev,
  input  logic [BYTE_W-1:0] rcon,
  output logic [BLK_W-1:0]  key_next
);

  localparam int WBYTES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] w_old [NCOL];
  logic [WORD_W-1:0] w_new [NCOL];
  logic [WORD_W-1:0] rot_w;
  logic [WORD_W-1:0] sub_w;
  logic [WORD_W-1:0] mix_w;

  for (genvar j = 0; j < NCOL; j++) begin : g_word
    assign w_old[j] = key_prev[BLK_W-1-WORD_W*j -: WORD_W];
  end

  assign rot_w = {w_old[NCOL-1][WORD_W-BYTE_W-1:0], w_old[NCOL-1][WORD_W-1 -: BYTE_W]};

  for (genvar b = 0; b < WBYTES; b++) begin : g_sw
    assign sub_w[WORD_W-1-BYTE_W*b -: BYTE_W] = sub_byte(rot_w[WORD_W-1-BYTE_W*b -: BYTE_W]);
  end

  assign mix_w = sub_w ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};

  for (genvar j = 0; j < NCOL; j++) begin : g_chain
    if (j == 0) begin : g_head
      assign w_new[j] = w_old[j] ^ mix_w;
    end else begin : g_tail
      assign w_new[j] = w_old[j] ^ w_new[j-1];
    end
    assign key_next[BLK_W-1-WORD_W*j -: WORD_W] = w_new[j];
  end

endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
  import aes_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BLK_W-1:0] plaintext,
  input  logic [BLK_W-1:0] key,
  output logic [BLK_W-1:0] ciphertext,
  output logic             done
);

  logic sel_ext, use_in_key, en_sub, en_shift, en_mix, en_ark, ld_work, ld_out;

  logic [BLK_W-1:0]  state_q;
  logic [BLK_W-1:0]  rk_q;
  logic [BYTE_W-1:0] rcon_q;
  logic [BLK_W-1:0]  ct_q;
  logic              done_q;

  logic [BLK_W-1:0]  round_in;
  logic [BLK_W-1:0]  round_out;
  logic [BLK_W-1:0]  key_exp;
  logic [BLK_W-1:0]  key_use;

  aes_enc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sel_ext    (sel_ext),
    .use_in_key (use_in_key),
    .en_sub     (en_sub),
    .en_shift   (en_shift),
    .en_mix     (en_mix),
    .en_ark     (en_ark),
    .ld_work    (ld_work),
    .ld_out     (ld_out)
  );

  assign round_in = sel_ext ? plaintext : state_q;

  aes_key_step u_kstep (
    .key_prev (rk_q),
    .rcon     (rcon_q),
    .key_next (key_exp)
  );

  assign key_use = use_in_key ? key : key_exp;

  aes_round_dp u_dp (
    .din      (round_in),
    .rkey     (key_use),
    .en_sub   (en_sub),
    .en_shift (en_shift),
    .en_mix   (en_mix),
    .en_ark   (en_ark),
    .dout     (round_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      rk_q    <= '0;
      rcon_q  <= 8'h01;
      ct_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= ld_out;
      if (ld_work) begin
        state_q <= round_out;
        rk_q    <= key_use;
        rcon_q  <= use_in_key ? 8'h01 : gf_x2(rcon_q);
      end
      if (ld_out) ct_q <= round_out;
    end
  end

  assign ciphertext = ct_q;
  assign done       = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R3

  AST_CT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld_out |=> $stable(ct_q)); // R5

  AST_DONE_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_out |=> done_q); // R3

endmodule

// File: tb/aes128_iter_enc_test.sv
module aes128_iter_enc_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [127:0] pt;
  logic [127:0] ky;
  logic [127:0] ct;
  logic         done;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] sb_tab [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  aes128_iter_enc uut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .plaintext  (pt),
    .key        (ky),
    .ciphertext (ct),
    .done       (done)
  );

  function automatic logic [7:0] m2(input logic [7:0] a);
    logic [8:0] t;
    t = {a, 1'b0};
    if (t[8]) t = t ^ 9'h11b;
    return t[7:0];
  endfunction

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] x;
    r = 0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = m2(x);
    end
    return r;
  endfunction

  task automatic build_sbox();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv;
      logic [7:0] o;
      logic [7:0] cst;
      inv = 0;
      for (int y = 1; y < 256; y++)
        if (mul(8'(v), 8'(y)) == 8'h01) inv = 8'(y);
      cst = 8'h63;
      for (int b = 0; b < 8; b++)
        o[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8] ^ cst[b];
      sb_tab[v] = o;
    end
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] p, input logic [127:0] k);
    logic [7:0]   st [16];
    logic [7:0]   rk [16];
    logic [7:0]   tp [16];
    logic [7:0]   rc;
    logic [7:0]   t0, t1, t2, t3;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      rk[i] = k[127-8*i -: 8];
      st[i] = p[127-8*i -: 8] ^ rk[i];
    end
    rc = 8'h01;
    for (int r = 1; r <= 10; r++) begin
      t0 = sb_tab[rk[13]] ^ rc;
      t1 = sb_tab[rk[14]];
      t2 = sb_tab[rk[15]];
      t3 = sb_tab[rk[12]];
      rk[0] ^= t0; rk[1] ^= t1; rk[2] ^= t2; rk[3] ^= t3;
      for (int i = 4; i < 16; i++) rk[i] ^= rk[i-4];
      rc = m2(rc);
      for (int i = 0; i < 16; i++) st[i] = sb_tab[st[i]];
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) tp[w + 4*c] = st[w + 4*((c + w) % 4)];
      for (int c = 0; c < 4; c++) begin
        if (r < 10) begin
          st[4*c]   = mul(tp[4*c],2) ^ mul(tp[4*c+1],3) ^ tp[4*c+2] ^ tp[4*c+3];
          st[4*c+1] = tp[4*c] ^ mul(tp[4*c+1],2) ^ mul(tp[4*c+2],3) ^ tp[4*c+3];
          st[4*c+2] = tp[4*c] ^ tp[4*c+1] ^ mul(tp[4*c+2],2) ^ mul(tp[4*c+3],3);
          st[4*c+3] = mul(tp[4*c],3) ^ tp[4*c+1] ^ tp[4*c+2] ^ mul(tp[4*c+3],2);
        end else begin
          for (int w = 0; w < 4; w++) st[4*c+w] = tp[4*c+w];
        end
      end
      for (int i = 0; i < 16; i++) st[i] ^= rk[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = st[i];
    return res;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one encryption from idle; optional start pokes while busy
  task automatic run_enc(input logic [127:0] p, input logic [127:0] k, input bit poke);
    logic [127:0] exp;
    int n;
    bit seen;
    exp = ref_enc(p, k);
    @(negedge clk);
    pt = p; ky = k; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    seen = 0;
    while (!seen && n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke) start = (n >= 4 && n <= 8);
      if (done) seen = 1;
    end
    start = 1'b0;
    check(n == 22, "R3 latency", 128'(n), 128'd22);
    check(ct == exp, "R4 ciphertext", ct, exp);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R3 single-cycle done", 128'(done), 128'd0);
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] hold_ct;
    int cnt;
    void'($urandom(32'h5eed_a35));
    build_sbox();
    rst = 1'b1; start = 1'b0; pt = '0; ky = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R1 done in reset", 128'(done), 128'd0);
    check(ct == '0, "R1 ciphertext in reset", ct, '0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0 && ct == '0, "R1 after reset release", ct, '0);

    // directed known-answer vectors
    check(ref_enc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f)
          == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 reference model", '0, '0);
    run_enc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, 0);
    check(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 known vector 1", ct,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run_enc(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, 0);
    check(ct == 128'h3925841d02dc09fbdc118597196a0b32, "R4 known vector 2", ct,
          128'h3925841d02dc09fbdc118597196a0b32);
    run_enc('0, '0, 0);
    run_enc('1, '1, 0);

    // R5: inputs change after completion, output must hold
    hold_ct = ct;
    @(negedge clk);
    pt = rnd128(); ky = rnd128();
    cnt = 0;
    repeat (12) begin
      @(posedge clk);
      @(negedge clk);
      if (done) cnt++;
    end
    check(ct == hold_ct, "R5 ciphertext holds", ct, hold_ct);
    check(cnt == 0, "R5 no done without start", 128'(cnt), 128'd0);

    // R2: start pokes while busy
    run_enc(rnd128(), rnd128(), 1);
    cnt = 0;
    repeat (30) begin
      @(posedge clk);
      @(negedge clk);
      if (done) cnt++;
    end
    check(cnt == 0, "R2 busy start ignored", 128'(cnt), 128'd0);

    // random vectors
    for (int v = 0; v < 8; v++) run_enc(rnd128(), rnd128(), 0);

    // R6: start held high, back-to-back completions
    begin
      logic [127:0] p, k, exp;
      int n, first, second, seen;
      p = rnd128(); k = rnd128(); exp = ref_enc(p, k);
      @(negedge clk);
      pt = p; ky = k; start = 1'b1;
      n = 0; first = 0; second = 0; seen = 0;
      @(posedge clk);
      while (seen < 2 && n < 80) begin
        @(posedge clk);
        n++;
        @(negedge clk);
        if (done) begin
          seen++;
          if (seen == 1) first = n; else second = n;
          check(ct == exp, "R6 back-to-back result", ct, exp);
        end
      end
      start = 1'b0;
      check(second - first == 25, "R6 completion spacing", 128'(second - first), 128'd25);
      repeat (3) @(posedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule